// File: doc/BRIEF.md
# Byte-Addressed GPIO Port Register Block

This block holds the data and direction registers of four general-purpose I/O ports behind a simple byte-wide slave bus. Ports A, B and D are eight bits wide. Port E is three bits wide. Each port drives an output vector and an output-enable vector toward its pads. Each port also takes an input vector from its pads and resynchronises it to the system clock. The bus has no handshake. A write takes effect at the clock edge on which `bus_we` is high. Read data is a combinational function of the presented address and the registered state.

A read of a data register returns the synchronised pin levels, not the value last written. A read of a direction register returns the stored bits. Port D differs from the others in its direction polarity: a cleared direction bit makes that pin an output. A mode input chooses between two address layouts. In big-endian mode the byte lane within each 32-bit word is mirrored.

Top module: `gpio_regblock`

## Requirements
- R1: After reset, every data register and every direction register is zero. All register reads return 0x00, and every `*_out` bit is 0.
- R2: For ports A, B and E, a direction bit of 1 sets the matching `*_oe` bit to 1, and a direction bit of 0 clears it.
- R3: For port D, `pd_oe` is the bitwise inverse of its direction register. Right after reset, `pd_oe` is therefore 0xFF.
- R4: A write to a data register latches `bus_wdata`. Each `*_out` bit equals the latched bit while that pin is an output, and is 0 while the pin is an input.
- R5: A read of a data register returns the synchronised pin input levels, whatever value was last written.
- R6: A change on a pin input first appears on `bus_rdata` after exactly two rising clock edges.
- R7: A read of a direction register returns the value stored by the last write to it.
- R8: With `big_endian`=0, the data registers sit at offsets A=0x00, B=0x01, D=0x03, port E=0x80. The direction registers sit at A=0x40, B=0x41, D=0x43, port E=0xC0.
- R9: With `big_endian`=1, the low two address bits are inverted before decoding. The offsets become A=0x03, B=0x02, D=0x00, E data=0x83, and A dir=0x43, B dir=0x42, D dir=0x40, E dir=0xC3.
- R10: Writes to any other offset, including lane 2 of each group, change no register. Reads of those offsets return 0x00.
- R11: Port E keeps only `bus_wdata[2:0]`. Reads of port E registers return 0 in bits 7:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | 1 selects the mirrored byte-lane layout |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A drive value |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B drive value |
| pb_oe | output | 8 | Port B output enables |
| pd_in | input | 8 | Port D pin levels |
| pd_out | output | 8 | Port D drive value |
| pd_oe | output | 8 | Port D output enables (active when direction bit is 0) |
| pe_in | input | 3 | Port E pin levels |
| pe_out | output | 3 | Port E drive value |
| pe_oe | output | 3 | Port E output enables |

## Verification
A corrupted direction register shows up on the `*_oe` pins in the cycle after the bad write. It shows up on `*_out` in that same cycle, and in any direction read from then on. A decode or lane-swap fault appears at once on `bus_rdata`, as a zero or as a neighbouring register's value. It also appears on the wrong port's pins one edge after a write. A synchroniser with the wrong depth is caught by reading a data register one edge and then two edges after a pin change: the first read must still show the old level.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W  = 8;
  localparam int BYTE_W  = 8;
  localparam int WIDE_W  = 8;
  localparam int NARROW_W = 3;
  localparam int NPORT   = 4;

  typedef enum logic [1:0] {
    PIDX_A = 2'd0,
    PIDX_B = 2'd1,
    PIDX_D = 2'd2,
    PIDX_E = 2'd3
  } port_idx_e;

  typedef enum logic [1:0] {
    GRP_WIDE_DATA  = 2'd0,
    GRP_WIDE_DIR   = 2'd1,
    GRP_NARROW_DATA = 2'd2,
    GRP_NARROW_DIR  = 2'd3
  } grp_e;

  function automatic logic [1:0] phys_lane(input logic [1:0] lane, input logic mirror);
    return lane ^ {2{mirror}};
  endfunction
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_pkg::*;
(
  input  logic              big_endian,
  input  logic [ADDR_W-1:0] addr,
  output logic [NPORT-1:0]  sel_data,
  output logic [NPORT-1:0]  sel_dir
);
  logic [1:0] lane;
  logic       hole;
  grp_e       grp;

  assign lane = phys_lane(addr[1:0], big_endian);
  assign hole = |addr[ADDR_W-3:2];
  assign grp  = grp_e'(addr[ADDR_W-1:ADDR_W-2]);

  always_comb begin
    sel_data = '0;
    sel_dir  = '0;
    if (!hole) begin
      unique case (grp)
        GRP_WIDE_DATA, GRP_WIDE_DIR: begin
          logic [NPORT-1:0] hit;
          hit = '0;
          case (lane)
            2'd0: hit[PIDX_A] = 1'b1;
            2'd1: hit[PIDX_B] = 1'b1;
            2'd3: hit[PIDX_D] = 1'b1;
            default: hit = '0;
          endcase
          if (grp == GRP_WIDE_DATA) sel_data = hit;
          else                      sel_dir  = hit;
        end
        GRP_NARROW_DATA: sel_data[PIDX_E] = (lane == 2'd0);
        GRP_NARROW_DIR:  sel_dir[PIDX_E]  = (lane == 2'd0);
        default: ;
      endcase
    end
  end

  // R8 R9: at most one register is addressed at a time
  always_comb begin
    a_r8_single_select: assert ($onehot0({sel_data, sel_dir}));
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W          = 8,
  parameter bit DIR_LOW_OUT = 1'b0,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data_en,
  input  logic         wr_dir_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] rd_dir
);
  logic [W-1:0] data_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] sync_q [SYNC_DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_data_en) data_q <= wdata;
      if (wr_dir_en)  dir_q  <= wdata;
    end
  end

  generate
    for (genvar s = 0; s < SYNC_DEPTH; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n)      sync_q[s] <= '0;
        else if (s == 0) sync_q[s] <= pin_in;
        else             sync_q[s] <= sync_q[s-1];
      end
    end
    if (DIR_LOW_OUT) begin : g_pol_low
      assign pin_oe = ~dir_q;
    end else begin : g_pol_high
      assign pin_oe = dir_q;
    end
  endgenerate

  assign pin_out = data_q & pin_oe;
  assign rd_data = sync_q[SYNC_DEPTH-1];
  assign rd_dir  = dir_q;

  // cycles since reset, saturating, for the latency check
  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  a_r6_two_edge_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> rd_data == $past(pin_in, 2));
  a_r7_dir_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_en |=> rd_dir == $past(wdata));
  a_r4_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_data_en && !wr_dir_en) |=> $stable(pin_out) && $stable(pin_oe));
endmodule

// File: rtl/gpio_regblock.sv
module gpio_regblock
  import gpio_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                big_endian,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [BYTE_W-1:0]   bus_wdata,
  output logic [BYTE_W-1:0]   bus_rdata,
  input  logic [WIDE_W-1:0]   pa_in,
  output logic [WIDE_W-1:0]   pa_out,
  output logic [WIDE_W-1:0]   pa_oe,
  input  logic [WIDE_W-1:0]   pb_in,
  output logic [WIDE_W-1:0]   pb_out,
  output logic [WIDE_W-1:0]   pb_oe,
  input  logic [WIDE_W-1:0]   pd_in,
  output logic [WIDE_W-1:0]   pd_out,
  output logic [WIDE_W-1:0]   pd_oe,
  input  logic [NARROW_W-1:0] pe_in,
  output logic [NARROW_W-1:0] pe_out,
  output logic [NARROW_W-1:0] pe_oe
);
  logic [NPORT-1:0] sel_data, sel_dir;
  logic [NPORT-1:0] wr_data, wr_dir;

  logic [WIDE_W-1:0]   a_rd, a_dir, b_rd, b_dir, d_rd, d_dir;
  logic [NARROW_W-1:0] e_rd, e_dir;

  gpio_addr_decode i_dec (
    .big_endian (big_endian),
    .addr       (bus_addr),
    .sel_data   (sel_data),
    .sel_dir    (sel_dir)
  );

  assign wr_data = sel_data & {NPORT{bus_we}};
  assign wr_dir  = sel_dir  & {NPORT{bus_we}};

  gpio_port #(.W(WIDE_W), .DIR_LOW_OUT(1'b0)) i_port_a (
    .clk(clk), .rst_n(rst_n),
    .wr_data_en(wr_data[PIDX_A]), .wr_dir_en(wr_dir[PIDX_A]),
    .wdata(bus_wdata), .pin_in(pa_in),
    .pin_out(pa_out), .pin_oe(pa_oe), .rd_data(a_rd), .rd_dir(a_dir)
  );

  gpio_port #(.W(WIDE_W), .DIR_LOW_OUT(1'b0)) i_port_b (
    .clk(clk), .rst_n(rst_n),
    .wr_data_en(wr_data[PIDX_B]), .wr_dir_en(wr_dir[PIDX_B]),
    .wdata(bus_wdata), .pin_in(pb_in),
    .pin_out(pb_out), .pin_oe(pb_oe), .rd_data(b_rd), .rd_dir(b_dir)
  );

  gpio_port #(.W(WIDE_W), .DIR_LOW_OUT(1'b1)) i_port_d (
    .clk(clk), .rst_n(rst_n),
    .wr_data_en(wr_data[PIDX_D]), .wr_dir_en(wr_dir[PIDX_D]),
    .wdata(bus_wdata), .pin_in(pd_in),
    .pin_out(pd_out), .pin_oe(pd_oe), .rd_data(d_rd), .rd_dir(d_dir)
  );

  gpio_port #(.W(NARROW_W), .DIR_LOW_OUT(1'b0)) i_port_e (
    .clk(clk), .rst_n(rst_n),
    .wr_data_en(wr_data[PIDX_E]), .wr_dir_en(wr_dir[PIDX_E]),
    .wdata(bus_wdata[NARROW_W-1:0]), .pin_in(pe_in),
    .pin_out(pe_out), .pin_oe(pe_oe), .rd_data(e_rd), .rd_dir(e_dir)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_data[PIDX_A]) bus_rdata = a_rd;
    if (sel_data[PIDX_B]) bus_rdata = b_rd;
    if (sel_data[PIDX_D]) bus_rdata = d_rd;
    if (sel_data[PIDX_E]) bus_rdata = {{(BYTE_W-NARROW_W){1'b0}}, e_rd};
    if (sel_dir[PIDX_A])  bus_rdata = a_dir;
    if (sel_dir[PIDX_B])  bus_rdata = b_dir;
    if (sel_dir[PIDX_D])  bus_rdata = d_dir;
    if (sel_dir[PIDX_E])  bus_rdata = {{(BYTE_W-NARROW_W){1'b0}}, e_dir};
  end

  a_r10_hole_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !(|{sel_data, sel_dir})) |=>
      $stable({a_dir, b_dir, d_dir, e_dir, pa_out, pb_out, pd_out, pe_out}));
  a_r10_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(|{sel_data, sel_dir}) |-> bus_rdata == '0);
  a_r3_d_reset_drives: assert property (@(posedge clk)
    $rose(rst_n) |-> pd_oe == '1);
endmodule

// File: tb/test_gpio_regblock.sv
module test_gpio_regblock;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       big_endian = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pa_in = '0, pa_out, pa_oe;
  logic [7:0] pb_in = '0, pb_out, pb_oe;
  logic [7:0] pd_in = '0, pd_out, pd_oe;
  logic [2:0] pe_in = '0, pe_out, pe_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  gpio_regblock i_gpio_regblock (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
    .pe_in(pe_in), .pe_out(pe_out), .pe_oe(pe_oe)
  );

  always #(CLK_P/2) clk = ~clk;

  // which output the monitor samples
  localparam int S_RD = 0, S_AOUT = 1, S_AOE = 2, S_BOUT = 3, S_BOE = 4,
                 S_DOUT = 5, S_DOE = 6, S_EOUT = 7, S_EOE = 8;

  typedef struct {
    int         sel;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb[$];
  event  sample_ev;

  initial begin
    forever begin
      @(sample_ev);
      while (sb.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sb.pop_front();
        case (it.sel)
          S_RD:   act = bus_rdata;
          S_AOUT: act = pa_out;
          S_AOE:  act = pa_oe;
          S_BOUT: act = pb_out;
          S_BOE:  act = pb_oe;
          S_DOUT: act = pd_out;
          S_DOE:  act = pd_oe;
          S_EOUT: act = {5'b0, pe_out};
          S_EOE:  act = {5'b0, pe_oe};
          default: act = 'x;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    bus_addr = addr; bus_wdata = data; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic expect_at(input int sel, input logic [7:0] addr,
                           input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = addr;
    #(CLK_P/4);
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    -> sample_ev;
  endtask

  initial begin
    #(CLK_P*100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_at(S_RD, 8'h00, 8'h00, "R1 A data");
    expect_at(S_RD, 8'h40, 8'h00, "R1 A dir");
    expect_at(S_RD, 8'h43, 8'h00, "R1 D dir");
    expect_at(S_RD, 8'hC0, 8'h00, "R1 E dir");
    expect_at(S_AOE, 8'h00, 8'h00, "R1 R2 A oe");
    expect_at(S_DOUT, 8'h00, 8'h00, "R1 D out");
    expect_at(S_DOE, 8'h00, 8'hFF, "R3 D oe after reset");

    // R2 R4 R7 R8 port A, little-endian
    wr(8'h40, 8'hF0);
    wr(8'h00, 8'hA5);
    expect_at(S_AOE, 8'h00, 8'hF0, "R2 A oe");
    expect_at(S_AOUT, 8'h00, 8'hA0, "R4 A out masked");
    expect_at(S_RD, 8'h40, 8'hF0, "R7 R8 A dir read");
    expect_at(S_RD, 8'h00, 8'h00, "R5 A data reads pins");

    // R3 port D inverted polarity
    wr(8'h43, 8'h0F);
    wr(8'h03, 8'h3C);
    expect_at(S_DOE, 8'h00, 8'hF0, "R3 D oe inverted");
    expect_at(S_DOUT, 8'h00, 8'h30, "R3 R4 D out");
    expect_at(S_RD, 8'h43, 8'h0F, "R7 R8 D dir read");

    // port B
    wr(8'h41, 8'hFF);
    wr(8'h01, 8'h5A);
    expect_at(S_BOE, 8'h00, 8'hFF, "R2 B oe");
    expect_at(S_BOUT, 8'h00, 8'h5A, "R4 R8 B out");

    // R11 port E narrow
    wr(8'hC0, 8'hFD);
    expect_at(S_RD, 8'hC0, 8'h05, "R11 E dir upper bits dropped");
    expect_at(S_EOE, 8'h00, 8'h05, "R2 E oe");
    wr(8'h80, 8'hFF);
    expect_at(S_EOUT, 8'h00, 8'h05, "R4 R11 E out");

    // R10 reserved / unmapped offsets
    wr(8'h02, 8'hFF);
    wr(8'h42, 8'hFF);
    wr(8'h44, 8'hFF);
    wr(8'hC1, 8'h00);
    wr(8'h81, 8'h00);
    expect_at(S_RD, 8'h02, 8'h00, "R10 lane2 data reads zero");
    expect_at(S_RD, 8'h42, 8'h00, "R10 lane2 dir reads zero");
    expect_at(S_RD, 8'h44, 8'h00, "R10 unmapped reads zero");
    expect_at(S_AOUT, 8'h00, 8'hA0, "R10 A out unchanged");
    expect_at(S_RD, 8'h43, 8'h0F, "R10 D dir unchanged");
    expect_at(S_RD, 8'hC0, 8'h05, "R10 E dir unchanged");
    expect_at(S_EOUT, 8'h00, 8'h05, "R10 E out unchanged");

    // R5 R6 pin synchronisation latency
    bus_addr = 8'h00;
    @(negedge clk);
    pa_in = 8'h3C;
    pb_in = 8'h81;
    pd_in = 8'h66;
    pe_in = 3'b110;
    expect_at(S_RD, 8'h00, 8'h00, "R6 one edge still old");
    expect_at(S_RD, 8'h00, 8'h3C, "R5 R6 two edges new");
    expect_at(S_RD, 8'h03, 8'h66, "R5 D data reads pins");
    expect_at(S_RD, 8'h80, 8'h06, "R5 R11 E data reads pins");

    // R9 big-endian layout
    @(negedge clk);
    big_endian = 1'b1;
    expect_at(S_RD, 8'h03, 8'h3C, "R9 A data at 03");
    expect_at(S_RD, 8'h02, 8'h81, "R9 B data at 02");
    expect_at(S_RD, 8'h00, 8'h66, "R9 D data at 00");
    expect_at(S_RD, 8'h43, 8'hF0, "R9 A dir at 43");
    expect_at(S_RD, 8'h40, 8'h0F, "R9 D dir at 40");
    expect_at(S_RD, 8'hC3, 8'h05, "R9 E dir at C3");
    expect_at(S_RD, 8'h83, 8'h06, "R9 E data at 83");
    expect_at(S_RD, 8'h01, 8'h00, "R9 R10 lane2 at 01 reads zero");
    expect_at(S_RD, 8'hC0, 8'h00, "R9 R10 C0 reserved");
    wr(8'h40, 8'hFF);
    expect_at(S_DOE, 8'h00, 8'h00, "R9 R3 D dir write at 40");
    wr(8'h42, 8'h00);
    expect_at(S_BOE, 8'h00, 8'h00, "R9 B dir write at 42");
    wr(8'h01, 8'hFF);
    expect_at(S_AOUT, 8'h00, 8'hA0, "R9 R10 lane2 write ignored");
    expect_at(S_BOUT, 8'h00, 8'h00, "R9 R4 B out off as input");

    #1;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule